// File: doc/BRIEF.md
# Vector Shift-Left, Insert and Widening Unit

This block is the execution datapath for the immediate left-shift family of a 128-bit vector unit. One operation is presented per cycle with a valid strobe. The block decodes the lane size and shift amount from a 7-bit immediate pair. It then applies one of three operations to every lane at once. The first is a left shift that fills with zeros. The second is a left shift that keeps the low bits of the previous destination below the shift point. The third is a widening shift: it takes one 64-bit half of the source, extends each lane to twice its width and shifts it.

The result appears one cycle later together with two flags. One flag marks encodings that are not allocated for the chosen operation. The other marks opcodes this unit does not execute. When either flag is raised, the previous destination value is passed through unchanged, so the register file can write back without a special case.

Top module: `vshl_unit`

## Requirements
- R1: The lane width is 8, 16, 32 or 64 bits, picked by the highest set bit of `imm_hi` (bit 0, 1, 2 or 3 in that order). The shift amount is `{imm_hi, imm_lo}` minus the lane width, which gives a value from 0 to lane width minus 1.
- R2: With `op_code` = 5'h0A and `u_bit` = 0, every result lane is the matching source lane shifted left with zeros filled in. Bits shifted past the top of a lane are dropped and never reach the next lane.
- R3: With `op_code` = 5'h0A and `u_bit` = 1, each result lane keeps the low `shift` bits of the matching `dst_old` lane. Its upper bits take the source lane shifted left. A shift of 0 copies the source lane whole.
- R4: For `op_code` 5'h0A with `q_bit` = 0, result bits [127:64] are zero.
- R5: For `op_code` 5'h0A, a 64-bit lane with `q_bit` = 0 is unallocated. For both 5'h0A and 5'h14, `imm_hi` = 0 is unallocated.
- R6: With `op_code` = 5'h14, source lanes are read from `src` bits [63:0] when `q_bit` = 0 and from bits [127:64] when `q_bit` = 1. Source lane k goes to result lane k, which is twice as wide.
- R7: Each widening lane is zero-extended when `u_bit` = 1 and sign-extended when `u_bit` = 0, then shifted left by the amount. The whole 128-bit result is written.
- R8: For `op_code` 5'h14, a lane width of 64 (`imm_hi[3]` = 1) is unallocated.
- R9: Any `op_code` other than 5'h0A and 5'h14 sets `unsupported`, clears `unalloc`, and returns `dst_old` unchanged.
- R10: An unallocated encoding sets `unalloc`, clears `unsupported`, and returns `dst_old` unchanged.
- R11: Outputs are registered. An operation accepted with `in_valid` at one rising edge is on the outputs after that edge, with `out_valid` high. Without `in_valid`, `out_valid` is low and the result holds. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| imm_hi | input | 4 | Upper immediate field; its highest set bit selects the lane size |
| imm_lo | input | 3 | Lower immediate field |
| op_code | input | 5 | Operation selector (5'h0A shift/insert, 5'h14 widening) |
| u_bit | input | 1 | Insert select for 5'h0A; zero-extend select for 5'h14 |
| q_bit | input | 1 | Full-width select; source half select for widening |
| src | input | 128 | Source vector |
| dst_old | input | 128 | Previous destination vector |
| out_valid | output | 1 | Result registered from an accepted operation |
| result | output | 128 | Result vector |
| unalloc | output | 1 | Encoding not allocated |
| unsupported | output | 1 | Opcode not handled by this unit |

## Verification
Plain shifts use sources with set bits at the top of each lane, so any carry across a lane boundary shows up. Insert runs use a destination pattern that differs from the source, with shifts of 0, a middle value and the maximum. This separates kept bits from shifted bits and exposes an off-by-one in the mask. Widening runs use lanes with their top bit set in both halves, under both extension modes. That tells sign extension from zero extension and the low half from the high half. A long random mix of opcodes, sizes and flags, including unallocated and unsupported encodings, is compared against a bit-level model of the requirements.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
   localparam logic [4:0] OPC_SHIFT = 5'h0A;
   localparam logic [4:0] OPC_WIDEN = 5'h14;
   localparam int         NUM_SIZES = 4;

   typedef enum logic [1:0] {
      KIND_SHIFT = 2'd0,
      KIND_WIDEN = 2'd1,
      KIND_OTHER = 2'd2
   } op_kind_t;

   function automatic logic [1:0] lane_size_idx(input logic [3:0] hi);
      if (hi[3])      return 2'd3;
      else if (hi[2]) return 2'd2;
      else if (hi[1]) return 2'd1;
      else            return 2'd0;
   endfunction
endpackage

// File: rtl/vshl_decode.sv
module vshl_decode
   import vshl_pkg::*;
(
   input  logic [3:0] imm_hi,
   input  logic [4:0] op_code,
   input  logic       q_bit,
   output op_kind_t   kind,
   output logic [1:0] size_idx,
   output logic       bad_enc
);
   always_comb begin
      size_idx = lane_size_idx(imm_hi);
      bad_enc  = 1'b0;
      if (op_code == OPC_SHIFT) begin
         kind    = KIND_SHIFT;
         bad_enc = (imm_hi == 4'd0) || (imm_hi[3] && !q_bit);
      end else if (op_code == OPC_WIDEN) begin
         kind    = KIND_WIDEN;
         bad_enc = (imm_hi == 4'd0) || imm_hi[3];
      end else begin
         kind    = KIND_OTHER;
      end
   end
endmodule

// File: rtl/vshl_lane_shift.sv
module vshl_lane_shift #(
   parameter int VW = 128,
   parameter int EW = 8
) (
   input  logic [VW-1:0] src,
   input  logic [VW-1:0] dst_old,
   input  logic [6:0]    imm_all,
   input  logic          keep_low,
   output logic [VW-1:0] res
);
   localparam int SHW = $clog2(EW);
   localparam int NL  = VW / EW;

   logic [6:0]     diff;
   logic [SHW-1:0] amt;
   logic [EW-1:0]  low_mask;

   assign diff     = imm_all - 7'(EW);
   assign amt      = diff[SHW-1:0];
   assign low_mask = ~({EW{1'b1}} << amt);

   for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [EW-1:0] s_l, d_l;
      assign s_l = src[l*EW +: EW];
      assign d_l = dst_old[l*EW +: EW];
      assign res[l*EW +: EW] = (s_l << amt) | (keep_low ? (d_l & low_mask) : '0);
   end
endmodule

// File: rtl/vshl_lane_widen.sv
module vshl_lane_widen #(
   parameter int VW = 128,
   parameter int EW = 8
) (
   input  logic [VW/2-1:0] half,
   input  logic [6:0]      imm_all,
   input  logic            zext,
   output logic [VW-1:0]   res
);
   localparam int SHW = $clog2(EW);
   localparam int NL  = (VW / 2) / EW;

   logic [6:0]     diff;
   logic [SHW-1:0] amt;

   assign diff = imm_all - 7'(EW);
   assign amt  = diff[SHW-1:0];

   for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [EW-1:0]   s_l;
      logic [2*EW-1:0] ext;
      assign s_l = half[l*EW +: EW];
      assign ext = zext ? {{EW{1'b0}}, s_l} : {{EW{s_l[EW-1]}}, s_l};
      assign res[l*2*EW +: 2*EW] = ext << amt;
   end
endmodule

// File: rtl/vshl_unit.sv
module vshl_unit
   import vshl_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [3:0]       imm_hi,
   input  logic [2:0]       imm_lo,
   input  logic [4:0]       op_code,
   input  logic             u_bit,
   input  logic             q_bit,
   input  logic [VEC_W-1:0] src,
   input  logic [VEC_W-1:0] dst_old,
   output logic             out_valid,
   output logic [VEC_W-1:0] result,
   output logic             unalloc,
   output logic             unsupported
);
   localparam int HALF_W = VEC_W / 2;

   if (VEC_W != 128) begin : g_bad_width
      $error("vshl_unit: VEC_W must be 128");
   end

   op_kind_t   kind;
   logic [1:0] size_idx;
   logic       bad_enc;
   logic [6:0] imm_all;

   assign imm_all = {imm_hi, imm_lo};

   vshl_decode u_decode (
      .imm_hi   (imm_hi),
      .op_code  (op_code),
      .q_bit    (q_bit),
      .kind     (kind),
      .size_idx (size_idx),
      .bad_enc  (bad_enc)
   );

   logic [VEC_W-1:0]  shl_res  [NUM_SIZES];
   logic [VEC_W-1:0]  wide_res [NUM_SIZES];
   logic [HALF_W-1:0] wide_src;

   assign wide_src = q_bit ? src[VEC_W-1:HALF_W] : src[HALF_W-1:0];

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      vshl_lane_shift #(.VW(VEC_W), .EW(8 << s)) u_shift (
         .src      (src),
         .dst_old  (dst_old),
         .imm_all  (imm_all),
         .keep_low (u_bit),
         .res      (shl_res[s])
      );
      if (s < NUM_SIZES - 1) begin : g_widen
         vshl_lane_widen #(.VW(VEC_W), .EW(8 << s)) u_widen (
            .half    (wide_src),
            .imm_all (imm_all),
            .zext    (u_bit),
            .res     (wide_res[s])
         );
      end else begin : g_no_widen
         assign wide_res[s] = '0;
      end
   end

   logic [VEC_W-1:0] next_res;
   logic             next_ua, next_us;

   always_comb begin
      next_res = dst_old;
      next_ua  = 1'b0;
      next_us  = 1'b0;
      if (kind == KIND_OTHER) begin
         next_us = 1'b1;
      end else if (bad_enc) begin
         next_ua = 1'b1;
      end else if (kind == KIND_SHIFT) begin
         next_res = q_bit ? shl_res[size_idx]
                          : {{HALF_W{1'b0}}, shl_res[size_idx][HALF_W-1:0]};
      end else begin
         next_res = wide_res[size_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         result      <= '0;
         unalloc     <= 1'b0;
         unsupported <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result      <= next_res;
            unalloc     <= next_ua;
            unsupported <= next_us;
         end
      end
   end

   assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));
   assert_q0_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == OPC_SHIFT && !q_bit && imm_hi != 4'd0 && !imm_hi[3])
      |=> (result[VEC_W-1:HALF_W] == '0 && !unalloc));
   assert_shift64_q0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == OPC_SHIFT && imm_hi[3] && !q_bit) |=> unalloc);
   assert_widen64_unalloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == OPC_WIDEN && imm_hi[3])
      |=> (unalloc && result == $past(dst_old)));
   assert_other_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code != OPC_SHIFT && op_code != OPC_WIDEN)
      |=> (unsupported && !unalloc && result == $past(dst_old)));
   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(unalloc && unsupported));
endmodule

// File: tb/vshl_unit_tb.sv
module vshl_unit_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   imm_hi = '0;
   logic [2:0]   imm_lo = '0;
   logic [4:0]   op_code = '0;
   logic         u_bit = 1'b0;
   logic         q_bit = 1'b0;
   logic [127:0] src = '0;
   logic [127:0] dst_old = '0;
   logic         out_valid;
   logic [127:0] result;
   logic         unalloc;
   logic         unsupported;

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct {
      logic [127:0] res;
      logic         ua;
      logic         us;
      string        tag;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;

   vshl_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .imm_hi(imm_hi), .imm_lo(imm_lo), .op_code(op_code),
      .u_bit(u_bit), .q_bit(q_bit), .src(src), .dst_old(dst_old),
      .out_valid(out_valid), .result(result),
      .unalloc(unalloc), .unsupported(unsupported)
   );

   function automatic exp_t model(input logic [3:0] hi, input logic [2:0] lo,
                                  input logic [4:0] op, input logic u, input logic q,
                                  input logic [127:0] s, input logic [127:0] d,
                                  input string tag);
      exp_t e;
      int sz, es, sh, base;
      e.tag = tag;
      e.res = d;
      e.ua  = 1'b0;
      e.us  = 1'b0;
      sz = hi[3] ? 3 : hi[2] ? 2 : hi[1] ? 1 : 0;
      es = 8 << sz;
      sh = int'({hi, lo}) - es;
      if (op != 5'h0A && op != 5'h14) begin
         e.us = 1'b1;
      end else if (hi == 4'd0 || (op == 5'h0A && sz == 3 && !q) ||
                   (op == 5'h14 && sz == 3)) begin
         e.ua = 1'b1;
      end else if (op == 5'h0A) begin
         for (int l = 0; l < 128 / es; l++)
            for (int b = 0; b < es; b++)
               if (b >= sh) e.res[l*es+b] = s[l*es+b-sh];
               else         e.res[l*es+b] = u ? d[l*es+b] : 1'b0;
         if (!q) e.res[127:64] = '0;
      end else begin
         base = q ? 64 : 0;
         for (int l = 0; l < 64 / es; l++)
            for (int b = 0; b < 2*es; b++) begin
               int j;
               j = b - sh;
               if (j < 0)       e.res[l*2*es+b] = 1'b0;
               else if (j < es) e.res[l*2*es+b] = s[base+l*es+j];
               else             e.res[l*2*es+b] = u ? 1'b0 : s[base+l*es+es-1];
            end
      end
      return e;
   endfunction

   task automatic drive(input logic [3:0] hi, input logic [2:0] lo, input logic [4:0] op,
                        input logic u, input logic q, input logic [127:0] s,
                        input logic [127:0] d, input string tag);
      @(negedge clk);
      imm_hi = hi; imm_lo = lo; op_code = op; u_bit = u; q_bit = q;
      src = s; dst_old = d; in_valid = 1'b1;
      sb.push_back(model(hi, lo, op, u, q, s, d, tag));
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         exp_t e;
         n_checks++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R11: result with empty scoreboard, act=%h", result);
         end else begin
            e = sb.pop_front();
            if (result !== e.res || unalloc !== e.ua || unsupported !== e.us) begin
               n_fail++;
               $display("FAIL %s: act res=%h ua=%b us=%b exp res=%h ua=%b us=%b",
                        e.tag, result, unalloc, unsupported, e.res, e.ua, e.us);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   localparam logic [127:0] PAT_A = 128'h8182_F0F0_7F01_C3A5_8000_0001_FFFF_1234;
   localparam logic [127:0] PAT_B = 128'h5A5A_5A5A_A5A5_A5A5_0F0F_0F0F_F0F0_F0F0;

   initial begin
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || result !== '0 || unalloc !== 1'b0 || unsupported !== 1'b0) begin
         n_fail++;
         $display("FAIL R11: reset act v=%b res=%h exp v=0 res=0", out_valid, result);
      end
      rst_n = 1'b1;

      drive(4'b0001, 3'd3, 5'h0A, 0, 1, PAT_A, PAT_B, "R2");
      drive(4'b0010, 3'd5, 5'h0A, 0, 1, PAT_A, PAT_B, "R2");
      drive(4'b0001, 3'd5, 5'h0A, 1, 1, PAT_A, PAT_B, "R3");
      drive(4'b0001, 3'd0, 5'h0A, 1, 1, PAT_A, PAT_B, "R3");
      drive(4'b0001, 3'd7, 5'h0A, 1, 1, PAT_A, PAT_B, "R3");
      drive(4'b0111, 3'd7, 5'h0A, 1, 1, PAT_A, PAT_B, "R1");
      drive(4'b1000, 3'd1, 5'h0A, 0, 1, PAT_A, PAT_B, "R1");
      drive(4'b1111, 3'd7, 5'h0A, 1, 1, PAT_A, PAT_B, "R3");
      drive(4'b0100, 3'd4, 5'h0A, 0, 0, PAT_A, PAT_B, "R4");
      drive(4'b1000, 3'd2, 5'h0A, 0, 0, PAT_A, PAT_B, "R5");
      drive(4'b0000, 3'd2, 5'h0A, 0, 1, PAT_A, PAT_B, "R5");
      drive(4'b0001, 3'd2, 5'h14, 1, 0, PAT_A, PAT_B, "R6");
      drive(4'b0001, 3'd2, 5'h14, 1, 1, PAT_A, PAT_B, "R6");
      drive(4'b0010, 3'd0, 5'h14, 0, 1, PAT_A, PAT_B, "R7");
      drive(4'b0010, 3'd0, 5'h14, 1, 1, PAT_A, PAT_B, "R7");
      drive(4'b0111, 3'd7, 5'h14, 0, 0, PAT_A, PAT_B, "R7");
      drive(4'b1001, 3'd0, 5'h14, 0, 1, PAT_A, PAT_B, "R8");
      drive(4'b0000, 3'd4, 5'h14, 0, 1, PAT_A, PAT_B, "R10");
      drive(4'b0001, 3'd1, 5'h00, 0, 1, PAT_A, PAT_B, "R9");
      drive(4'b0010, 3'd1, 5'h15, 1, 0, PAT_A, PAT_B, "R9");

      @(negedge clk);
      in_valid = 1'b0;
      src = ~PAT_A;
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R11: idle act out_valid=%b exp 0", out_valid);
      end

      for (int i = 0; i < 400; i++) begin
         logic [4:0] op;
         int pick;
         pick = int'($urandom_range(0, 9));
         op = (pick < 4) ? 5'h0A : (pick < 8) ? 5'h14 : 5'($urandom);
         drive(4'($urandom), 3'($urandom), op, 1'($urandom), 1'($urandom),
               {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom}, "R1");
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);

      n_checks++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R11: act pending=%0d exp 0", sb.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule